// File: doc/BRIEF.md
# Consecutive Out-of-Limit Alert Filter

This block sits behind a multi-channel temperature measurement engine and decides when a shared alert line should be raised. The engine delivers one reading per channel per conversion round. For each reading, the block compares the temperature with that channel's high and low limits and looks at the diode fault flag. It keeps a separate counter of consecutive bad readings for every channel. An alert is raised only after a programmed number of consecutive bad readings on the same channel, so a single noisy sample does not trigger it.

There are two modes. In interrupt mode, any high, low or fault result counts. When a channel reaches the programmed count, its sticky status bit and error-kind bits are latched, the alert is raised, and that channel's counter starts again from zero. The status bits and the alert stay set until a status acknowledge strobe. In comparator mode, only readings above the high limit count. Once the count is reached the alert stays raised, and the counter keeps its value, until a reading falls below the high limit minus a hysteresis value.

Limits, masks, hysteresis and the count setting are written over a simple parallel write port. Readings arrive on a valid/ready stream. Ready is high whenever reset is low, so the block never applies back-pressure. A reading is taken on every clock edge where valid and ready are both high. The producer may hold valid low for as long as it likes between readings.

Top module: `alert_filter`

## Requirements
- R1: After reset, alert, chan_status and all error bits are 0, the count setting is one consecutive reading (configuration reset value 0x70), all masks are 0, all high limits are 85, all low limits are 0, and the hysteresis is 5. meas_ready is 0 during reset and 1 otherwise.
- R2: A reading is accepted on a rising edge where meas_valid and meas_ready are both 1. Only the counter of the channel named by meas_chan changes, and outputs show the result from the next cycle. The counters of all other channels hold their values.
- R3: In interrupt mode (mode_cmp=0), a reading counts as bad if it is strictly above the channel's high limit, strictly below its low limit, or has meas_fault=1. A bad reading increments the counter. Any other reading, including one exactly equal to a limit, clears the counter.
- R4: In interrupt mode, a bad reading that brings the counter to the target count sets that channel's chan_status bit. It also ORs that reading's kinds into err_high, err_low and err_fault, and clears the counter.
- R5: In interrupt mode, alert is 1 while any unmasked channel has its chan_status bit set. A one-cycle status_ack clears all chan_status and error bits. A trigger in the same cycle as status_ack wins for its own bits.
- R6: A channel whose mask bit is 1 never drives alert, in either mode. In interrupt mode its status and error bits are still recorded.
- R7: Configuration bits 3:1 select the target count: 000 means 1, 001 means 2, 011 means 4, 111 means 8. Every other code means 1. Configuration bits 7:4 and 0 are ignored.
- R8: In comparator mode (mode_cmp=1), low-limit and fault results are ignored, and only a reading strictly above the high limit increments the counter. A non-high reading on a channel that is not latched clears its counter.
- R9: In comparator mode, reaching the target count latches the channel and keeps its counter (it is not cleared), and alert stays 1 for an unmasked latched channel. The latch is released, and the counter cleared, only by a reading strictly below high limit minus hysteresis. status_ack has no effect on it.
- R10: The write port (wr_en, wr_addr, wr_data) maps its addresses as follows: 0 is the configuration, 1 is the masks (bit i for channel i), 2 is the unsigned hysteresis, 4+i is the signed high limit of channel i, and 8+i is the signed low limit of channel i. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cmp | input | 1 | 0 selects interrupt mode, 1 selects comparator mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register write address |
| wr_data | input | 8 | Register write data |
| meas_valid | input | 1 | Reading valid |
| meas_ready | output | 1 | Reading accepted when valid; high whenever reset is low |
| meas_chan | input | CW (2) | Channel index of the reading |
| meas_temp | input | 8 | Signed temperature in degrees |
| meas_fault | input | 1 | Diode fault flag for the reading |
| status_ack | input | 1 | Clears sticky status and error bits |
| alert | output | 1 | Shared alert output |
| chan_status | output | NCH (3) | Sticky per-channel trigger status |
| err_high | output | NCH (3) | Latched high-limit kind per channel |
| err_low | output | NCH (3) | Latched low-limit kind per channel |
| err_fault | output | NCH (3) | Latched fault kind per channel |

## Verification
The assertions assume that mode_cmp changes only while reset is asserted. They also assume that meas_chan names an existing channel whenever a reading is accepted, and that NCH is at most four so the limit addresses do not overlap. The stimulus switches mode only inside a reset, sends readings only for channels 0 to 2, and leaves at least one idle cycle between readings. A single reading therefore never meets a register write or an acknowledge in the same cycle unless a check intends it.

// File: rtl/alert_filter_pkg.sv
package alert_filter_pkg;
  localparam int CNT_W = 4;

  typedef logic signed [7:0] temp_t;

  // R7: three-bit count code to required consecutive readings
  function automatic logic [CNT_W-1:0] count_target(input logic [2:0] code);
    case (code)
      3'b001:  return CNT_W'(2);
      3'b011:  return CNT_W'(4);
      3'b111:  return CNT_W'(8);
      default: return CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/alert_filter_regs.sv
module alert_filter_regs
  import alert_filter_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int AW      = 4,
  parameter int HI_BASE = 4,
  parameter int LO_BASE = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  output logic [2:0]            cnt_code,
  output logic [NCH-1:0]        mask,
  output logic [7:0]            hyst,
  output logic [NCH-1:0][7:0]   high_lim,
  output logic [NCH-1:0][7:0]   low_lim
);
  localparam logic [AW-1:0] A_CFG  = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_HYST = AW'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_code <= 3'b000;
      mask     <= '0;
      hyst     <= 8'd5;
      for (int i = 0; i < NCH; i++) begin
        high_lim[i] <= 8'd85;
        low_lim[i]  <= 8'd0;
      end
    end else if (wr_en) begin
      if (wr_addr == A_CFG)  cnt_code <= wr_data[3:1];
      if (wr_addr == A_MASK) mask     <= wr_data[NCH-1:0];
      if (wr_addr == A_HYST) hyst     <= wr_data;
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == AW'(HI_BASE + i)) high_lim[i] <= wr_data;
        if (wr_addr == AW'(LO_BASE + i)) low_lim[i]  <= wr_data;
      end
    end
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MASK) |=> (mask == $past(wr_data[NCH-1:0]))); // R10
  AST_HYST_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_HYST) |=> (hyst == $past(wr_data))); // R10
endmodule

// File: rtl/alert_filter_chan.sv
module alert_filter_chan
  import alert_filter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             mode_cmp,
  input  temp_t            temp,
  input  logic             fault,
  input  temp_t            high,
  input  temp_t            low,
  input  logic [7:0]       hyst,
  input  logic [CNT_W-1:0] target,
  input  logic             clr,
  output logic             fire,
  output logic             status,
  output logic             e_hi,
  output logic             e_lo,
  output logic             e_flt,
  output logic             active
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] next_cnt;
  logic             above, below, err_any, reach, under_rel;
  logic signed [9:0] rel;

  always_comb begin
    above     = temp > high;
    below     = temp < low;
    err_any   = above | below | fault;
    next_cnt  = cnt + CNT_W'(1);
    reach     = next_cnt >= target;
    rel       = $signed({{2{high[7]}}, high}) - $signed({2'b00, hyst});
    under_rel = $signed({{2{temp[7]}}, temp}) < rel;
    fire      = hit && !mode_cmp && err_any && reach;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      status <= 1'b0;
      e_hi   <= 1'b0;
      e_lo   <= 1'b0;
      e_flt  <= 1'b0;
    end else begin
      if (hit) begin
        if (!mode_cmp) begin
          if (!err_any || reach) cnt <= '0;
          else                   cnt <= next_cnt;
        end else if (above) begin
          if (cnt < target) cnt <= next_cnt;
          if (reach)        active <= 1'b1;
        end else if (under_rel || !active) begin
          cnt    <= '0;
          active <= 1'b0;
        end
      end
      status <= fire | (status & !clr);
      e_hi   <= (fire & above) | (e_hi  & !clr);
      e_lo   <= (fire & below) | (e_lo  & !clr);
      e_flt  <= (fire & fault) | (e_flt & !clr);
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(cnt) && $stable(active))); // R2
  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt == '0)); // R4
  AST_FIRE_STATUS: assert property (@(posedge clk) disable iff (rst)
    fire |=> status); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr && !fire) |=> !(status || e_hi || e_lo || e_flt)); // R5
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hit && mode_cmp && active && !under_rel) |=> active); // R9
  AST_CMP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (hit && mode_cmp && !above && under_rel) |=> (!active && cnt == '0)); // R9
  AST_CMP_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
    mode_cmp |-> !fire); // R8
endmodule

// File: rtl/alert_filter.sv
module alert_filter
  import alert_filter_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 4,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_cmp,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic           meas_valid,
  output logic           meas_ready,
  input  logic [CW-1:0]  meas_chan,
  input  logic [7:0]     meas_temp,
  input  logic           meas_fault,
  input  logic           status_ack,
  output logic           alert,
  output logic [NCH-1:0] chan_status,
  output logic [NCH-1:0] err_high,
  output logic [NCH-1:0] err_low,
  output logic [NCH-1:0] err_fault
);
  logic [2:0]           cnt_code;
  logic [NCH-1:0]       mask;
  logic [7:0]           hyst;
  logic [NCH-1:0][7:0]  high_lim;
  logic [NCH-1:0][7:0]  low_lim;
  logic [NCH-1:0]       fire;
  logic [NCH-1:0]       active;
  logic [CNT_W-1:0]     target;
  logic                 accept;

  assign meas_ready = !rst;
  assign accept     = meas_valid && meas_ready;
  assign target     = count_target(cnt_code);

  alert_filter_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_code(cnt_code), .mask(mask), .hyst(hyst),
    .high_lim(high_lim), .low_lim(low_lim)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    alert_filter_chan u_chan (
      .clk(clk), .rst(rst),
      .hit(accept && meas_chan == CW'(g)),
      .mode_cmp(mode_cmp),
      .temp(meas_temp), .fault(meas_fault),
      .high(high_lim[g]), .low(low_lim[g]),
      .hyst(hyst), .target(target), .clr(status_ack),
      .fire(fire[g]), .status(chan_status[g]),
      .e_hi(err_high[g]), .e_lo(err_low[g]), .e_flt(err_fault[g]),
      .active(active[g])
    );
  end

  assign alert = mode_cmp ? |(active & ~mask) : |(chan_status & ~mask);

  AST_FIRE_RAISES_ALERT: assert property (@(posedge clk) disable iff (rst)
    (|(fire & ~mask)) |=> alert); // R5
  AST_ONE_CHANNEL_FIRES: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fire)); // R2
endmodule

// File: tb/alert_filter_test.sv
module alert_filter_test;
  localparam int NCH = 3;

  logic       clk = 0;
  logic       rst = 1;
  logic       mode_cmp = 0;
  logic       wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic       meas_valid = 0;
  logic       meas_ready;
  logic [1:0] meas_chan = 0;
  logic [7:0] meas_temp = 0;
  logic       meas_fault = 0;
  logic       status_ack = 0;
  logic       alert;
  logic [NCH-1:0] chan_status, err_high, err_low, err_fault;

  int checks = 0;
  int failures = 0;

  bit         q_alert[$];
  logic [2:0] q_stat[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  alert_filter uut (
    .clk(clk), .rst(rst), .mode_cmp(mode_cmp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .meas_valid(meas_valid), .meas_ready(meas_ready), .meas_chan(meas_chan),
    .meas_temp(meas_temp), .meas_fault(meas_fault), .status_ack(status_ack),
    .alert(alert), .chan_status(chan_status),
    .err_high(err_high), .err_low(err_low), .err_fault(err_fault)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ack();
    @(negedge clk);
    status_ack = 1;
    @(negedge clk);
    status_ack = 0;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1; mode_cmp = m;
    repeat (2) @(negedge clk);
    chk(meas_ready == 0, "R1 ready low in reset", meas_ready, 0);
    rst = 0;
  endtask

  // driver: sends one reading and queues the expected outputs
  task automatic rd(input int ch, input int t, input bit f,
                    input bit ea, input logic [2:0] es, input string tag);
    @(negedge clk);
    meas_valid = 1; meas_chan = 2'(ch); meas_temp = 8'(t); meas_fault = f;
    q_alert.push_back(ea); q_stat.push_back(es); q_tag.push_back(tag);
    @(negedge clk);
    meas_valid = 0; meas_fault = 0;
  endtask

  // monitor: compares after every accepted reading
  always @(posedge clk) begin
    if (meas_valid && meas_ready) begin
      @(negedge clk);
      if (q_tag.size() == 0) begin
        chk(0, "R2 unexpected accept", 1, 0);
      end else begin
        bit ea; logic [2:0] es; string tg;
        ea = q_alert.pop_front(); es = q_stat.pop_front(); tg = q_tag.pop_front();
        chk(alert == ea, {tg, " alert"}, alert, ea);
        chk(chan_status == es, {tg, " status"}, chan_status, es);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // ---------------- interrupt mode ----------------
    do_reset(0);
    @(negedge clk);
    chk(alert == 0 && chan_status == 0, "R1 reset outputs", {alert, chan_status}, 0);
    chk((err_high | err_low | err_fault) == 0, "R1 reset errors", err_high | err_low | err_fault, 0);
    chk(meas_ready == 1, "R1 ready after reset", meas_ready, 1);
    // R1 default count of 1 with default high 85
    rd(0, 86, 0, 1, 3'b001, "R1 default count one");
    ack();
    @(negedge clk);
    chk(alert == 0 && chan_status == 0, "R5 ack clears", {alert, chan_status}, 0);

    for (int i = 0; i < 3; i++) begin
      wreg(4'(4 + i), 8'd70);
      wreg(4'(8 + i), 8'hF6);
    end
    wreg(4'd0, 8'h76);  // R7 code 011 -> 4
    rd(0, 71, 0, 0, 3'b000, "R3 c1 ch0");
    rd(1, 69, 0, 0, 3'b000, "R3 c1 ch1");
    rd(2, 69, 0, 0, 3'b000, "R3 c1 ch2");
    rd(0, 71, 0, 0, 3'b000, "R3 c2 ch0");
    rd(1, 71, 0, 0, 3'b000, "R3 c2 ch1");
    rd(2, 68, 0, 0, 3'b000, "R3 c2 ch2");
    rd(0, 69, 0, 0, 3'b000, "R3 c3 ch0");
    rd(1, 71, 0, 0, 3'b000, "R2 c3 ch1");
    rd(2, 69, 0, 0, 3'b000, "R3 c3 ch2");
    rd(0, 71, 0, 0, 3'b000, "R3 c4 ch0");
    rd(1, 71, 0, 0, 3'b000, "R2 c4 ch1");
    rd(2, 71, 0, 0, 3'b000, "R3 c4 ch2");
    rd(0, 71, 0, 0, 3'b000, "R3 c5 ch0");
    rd(1, 71, 0, 1, 3'b010, "R4 c5 ch1 fires");
    rd(2, 71, 0, 1, 3'b010, "R2 c5 ch2 held");
    @(negedge clk);
    chk(err_high == 3'b010 && err_low == 0 && err_fault == 0, "R4 error kinds", err_high, 3'b010);
    ack();
    @(negedge clk);
    chk(alert == 0 && chan_status == 0 && err_high == 0, "R5 ack clears all", {alert, chan_status}, 0);

    // ch0 counter is 2; a reading equal to the limit clears it
    rd(0, 70, 0, 0, 3'b000, "R3 equal limit");
    rd(0, 71, 0, 0, 3'b000, "R3 after clear 1");
    rd(0, 71, 0, 0, 3'b000, "R3 after clear 2");
    rd(0, 71, 0, 0, 3'b000, "R3 after clear 3");
    rd(0, 71, 0, 1, 3'b001, "R4 after clear 4");
    rd(0, 71, 0, 1, 3'b001, "R4 counter restarted");
    ack();

    wreg(4'd0, 8'h70);  // count 1
    rd(2, 20, 1, 1, 3'b100, "R3 fault counts");
    @(negedge clk);
    chk(err_fault == 3'b100 && err_high == 0, "R4 fault kind", err_fault, 3'b100);
    ack();

    wreg(4'd1, 8'h01);  // mask ch0
    rd(0, -20, 0, 0, 3'b001, "R6 masked records status");
    @(negedge clk);
    chk(err_low == 3'b001, "R3 low kind", err_low, 3'b001);
    ack();
    wreg(4'd1, 8'h00);

    wreg(4'd0, 8'h74);  // code 010 -> 1
    rd(1, 71, 0, 1, 3'b010, "R7 other code one");
    ack();
    wreg(4'd0, 8'h72);  // code 001 -> 2
    rd(1, 71, 0, 0, 3'b000, "R7 code two first");
    rd(1, 71, 0, 1, 3'b010, "R7 code two second");
    ack();
    wreg(4'd0, 8'h7E);  // code 111 -> 8
    for (int k = 0; k < 7; k++) rd(2, 71, 0, 0, 3'b000, "R7 code eight below");
    rd(2, 71, 0, 1, 3'b100, "R7 code eight reached");

    // set wins over a same-cycle acknowledge
    wreg(4'd0, 8'h70);
    @(negedge clk);
    meas_valid = 1; meas_chan = 2'd0; meas_temp = 8'd71; status_ack = 1;
    q_alert.push_back(1); q_stat.push_back(3'b001); q_tag.push_back("R5 set wins over ack");
    @(negedge clk);
    meas_valid = 0; status_ack = 0;
    ack();

    // ---------------- comparator mode ----------------
    do_reset(1);
    wreg(4'd4, 8'd70);
    wreg(4'd8, 8'd50);
    wreg(4'd2, 8'd5);
    wreg(4'd0, 8'h72);  // count 2
    rd(0, 40, 0, 0, 3'b000, "R8 low ignored");
    rd(0, 60, 1, 0, 3'b000, "R8 fault ignored");
    rd(0, 71, 0, 0, 3'b000, "R8 first high");
    rd(0, 68, 0, 0, 3'b000, "R8 non-high clears");
    rd(0, 71, 0, 0, 3'b000, "R8 restart");
    rd(0, 71, 0, 1, 3'b000, "R9 latched");
    rd(1, 20, 0, 1, 3'b000, "R9 other channel");
    rd(0, 68, 0, 1, 3'b000, "R9 inside band");
    rd(0, 65, 0, 1, 3'b000, "R9 at release level");
    ack();
    @(negedge clk);
    chk(alert == 1, "R9 ack no effect", alert, 1);
    rd(0, 64, 0, 0, 3'b000, "R9 released");
    rd(0, 71, 0, 0, 3'b000, "R9 counter cleared");
    rd(0, 71, 0, 1, 3'b000, "R9 relatched");
    wreg(4'd1, 8'h01);
    @(negedge clk);
    chk(alert == 0, "R6 comparator mask", alert, 0);
    chk(meas_ready == 1, "R2 ready", meas_ready, 1);

    repeat (3) @(negedge clk);
    chk(q_tag.size() == 0, "R2 all readings seen", q_tag.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule